// File: doc/BRIEF.md
# Display Trigger Interrupt Generator

This block produces the trigger interrupt for a command-driven display panel. It runs on the pixel clock. Software controls it through a 32-bit configuration word that holds two counter factors and a two-bit operating mode. A second word holds a sticky status flag.

In periodic mode, three cascaded stages generate the interrupt. The first stage is a fixed divide-by-4 prescaler. It drives a stage that counts up to factor M, and that stage drives a stage that counts up to factor N. The interrupt fires when all three stages wrap together. In the two tearing-effect modes, the block takes over the first general-purpose interface pin as an input. It synchronises the pin and raises the interrupt once for each rising edge or each falling edge, depending on the mode.

Every interrupt is a one-clock pulse, and each pulse also sets the status flag. Software clears the flag by writing a one to it. Writing the configuration word restarts the counters, so the new period begins from the moment of the write.

Top module: `disp_trig_irq`

## Requirements
- R1: After reset the configuration word reads 0, the status word reads 0, `irq_pulse` is low and `io0_is_te` is low.
- R2: The configuration word (`rd_addr`=0 / `wr_addr`=0) holds factor M in bits 7:0, factor N in bits 23:8 and the mode in bits 29:28. Bits 27:24 and 31:30 always read 0.
- R3: In mode 1, pulses repeat every (N+1)*(M+1)*4 clocks. The first pulse is high in clock P = (N+1)*(M+1)*4 after the configuration write edge.
- R4: Each interrupt is high for exactly one clock.
- R5: Any write to the configuration word restarts the count, so the next pulse comes a full period after that write.
- R6: In mode 2, each rising edge of `te_pin` gives exactly one pulse. A level first sampled at edge A gives a pulse that is high after edge A+2.
- R7: In mode 3, each falling edge of `te_pin` gives exactly one pulse, with the same latency as R6. Rising edges give no pulse in this mode.
- R8: In mode 0, no pulse is produced and edges on `te_pin` are ignored.
- R9: Each pulse sets the status flag, which reads back as bit 0 of the status word (address 1). Writing 1 to bit 0 of address 1 clears the flag one edge later. If a pulse falls in the same cycle as the clear, the flag stays set.
- R10: `io0_is_te` is high exactly while the mode is 2 or 3.
- R11: In the tearing-effect modes no periodic pulse occurs while `te_pin` is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write word select: 0 configuration, 1 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read word select: 0 configuration, 1 status |
| rd_data | output | 32 | Read data |
| te_pin | input | 1 | Tearing-effect input taken from the first interface pin |
| io0_is_te | output | 1 | High while the first interface pin serves as the tearing-effect input |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| irq_status | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: 8-bit M, 16-bit N, a two-bit prescaler (divide by 4) and a two-flop synchroniser. These match the register layout, so the full M range is reachable, including M=255 for a 1024-clock period. N is kept small so that periods stay short. The two-flop synchroniser fixes the tearing-effect latency at two edges, which the bench checks exactly. The status set-versus-clear collision is reached deterministically with M=N=0, where the period is 4 clocks.

// File: rtl/disp_trig_pkg.sv
package disp_trig_pkg;
   typedef enum logic [1:0] {
      TRIG_OFF     = 2'd0,
      TRIG_COUNT   = 2'd1,
      TRIG_TE_RISE = 2'd2,
      TRIG_TE_FALL = 2'd3
   } trig_mode_e;

   localparam int REG_W     = 32;
   localparam int M_LSB     = 0;
   localparam int M_MAX_W   = 8;
   localparam int N_LSB     = 8;
   localparam int N_MAX_W   = 16;
   localparam int MODE_LSB  = 28;
   localparam int MODE_W    = 2;
endpackage

// File: rtl/trig_wrap_cnt.sv
module trig_wrap_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic [W-1:0] value,
   output logic         wrap
);
   assign wrap = step && !clr && (value == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else if (clr)
         value <= '0;
      else if (step)
         value <= (value == limit) ? '0 : value + 1'b1;
   end
endmodule

// File: rtl/trig_period_chain.sv
module trig_period_chain #(
   parameter int PRE_W = 2,
   parameter int M_W   = 8,
   parameter int N_W   = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic [M_W-1:0] fac_m,
   input  logic [N_W-1:0] fac_n,
   output logic           period_hit
);
   localparam int PRE_DIV = 1 << PRE_W;

   logic pre_tick;
   logic m_wrap;
   logic [M_W-1:0] m_val;
   logic [N_W-1:0] n_val;

   generate
      if (PRE_W == 0) begin : g_no_pre
         assign pre_tick = !hold;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_val;
         trig_wrap_cnt #(.W(PRE_W)) i_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (hold),
            .step  (1'b1),
            .limit (PRE_W'(PRE_DIV - 1)),
            .value (pre_val),
            .wrap  (pre_tick)
         );
      end
   endgenerate

   trig_wrap_cnt #(.W(M_W)) i_m_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold),
      .step  (pre_tick),
      .limit (fac_m),
      .value (m_val),
      .wrap  (m_wrap)
   );

   trig_wrap_cnt #(.W(N_W)) i_n_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold),
      .step  (m_wrap),
      .limit (fac_n),
      .value (n_val),
      .wrap  (period_hit)
   );

   logic unused_vals;
   assign unused_vals = ^{m_val, n_val};
endmodule

// File: rtl/trig_te_edge.sv
module trig_te_edge #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [SYNC_N-1:0] sync_q;
   logic              prev_q;
   logic              stable;

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("trig_te_edge: SYNC_N must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], pin};
         prev_q <= stable;
      end
   end

   assign stable = sync_q[SYNC_N-1];
   assign rise   = stable & ~prev_q;
   assign fall   = ~stable & prev_q;
endmodule

// File: rtl/trig_status.sv
module trig_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end
endmodule

// File: rtl/disp_trig_irq.sv
module disp_trig_irq
   import disp_trig_pkg::*;
#(
   parameter int M_W    = 8,
   parameter int N_W    = 16,
   parameter int PRE_W  = 2,
   parameter int SYNC_N = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_addr,
   input  logic [31:0] wr_data,
   input  logic        rd_addr,
   output logic [31:0] rd_data,
   input  logic        te_pin,
   output logic        io0_is_te,
   output logic        irq_pulse,
   output logic        irq_status
);
   generate
      if (M_W < 1 || M_W > M_MAX_W) begin : g_bad_m
         $error("disp_trig_irq: M_W out of range");
      end
      if (N_W < 1 || N_W > N_MAX_W) begin : g_bad_n
         $error("disp_trig_irq: N_W out of range");
      end
      if (PRE_W < 0 || PRE_W > 8) begin : g_bad_pre
         $error("disp_trig_irq: PRE_W out of range");
      end
   endgenerate

   logic [M_W-1:0] cfg_m;
   logic [N_W-1:0] cfg_n;
   trig_mode_e     cfg_mode;
   logic           cfg_wr;
   logic           st_clr;
   logic           run_hold;
   logic           period_hit;
   logic           te_rise;
   logic           te_fall;
   logic           irq_next;
   logic           irq_q;

   assign cfg_wr = wr_en && (wr_addr == 1'b0);
   assign st_clr = wr_en && (wr_addr == 1'b1) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_m    <= '0;
         cfg_n    <= '0;
         cfg_mode <= TRIG_OFF;
      end else if (cfg_wr) begin
         cfg_m    <= wr_data[M_LSB +: M_W];
         cfg_n    <= wr_data[N_LSB +: N_W];
         cfg_mode <= trig_mode_e'(wr_data[MODE_LSB +: MODE_W]);
      end
   end

   assign run_hold = cfg_wr || (cfg_mode != TRIG_COUNT);

   trig_period_chain #(.PRE_W(PRE_W), .M_W(M_W), .N_W(N_W)) i_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (run_hold),
      .fac_m      (cfg_m),
      .fac_n      (cfg_n),
      .period_hit (period_hit)
   );

   trig_te_edge #(.SYNC_N(SYNC_N)) i_te (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (te_pin),
      .rise  (te_rise),
      .fall  (te_fall)
   );

   always_comb begin
      unique case (cfg_mode)
         TRIG_COUNT:   irq_next = period_hit;
         TRIG_TE_RISE: irq_next = te_rise;
         TRIG_TE_FALL: irq_next = te_fall;
         default:      irq_next = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= irq_next;
   end

   trig_status i_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq_next),
      .clr   (st_clr),
      .flag  (irq_status)
   );

   assign irq_pulse = irq_q;
   assign io0_is_te = (cfg_mode == TRIG_TE_RISE) || (cfg_mode == TRIG_TE_FALL);

   always_comb begin
      rd_data = '0;
      if (rd_addr == 1'b0) begin
         rd_data[M_LSB +: M_W]       = cfg_m;
         rd_data[N_LSB +: N_W]       = cfg_n;
         rd_data[MODE_LSB +: MODE_W] = cfg_mode;
      end else begin
         rd_data[0] = irq_status;
      end
   end

   logic unused_wr;
   assign unused_wr = ^wr_data;
endmodule

// File: rtl/disp_trig_chk.sv
module disp_trig_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_addr,
   input logic [31:0] wr_data,
   input logic        rd_addr,
   input logic [31:0] rd_data,
   input logic [1:0]  mode_q,
   input logic        io0_is_te,
   input logic        irq_pulse,
   input logic        irq_status
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse); // R4

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0) |=> !irq_pulse); // R8

   AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_status); // R9

   AST_CLEAR_OR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && wr_data[0]) |=> (irq_status == irq_pulse)); // R9

   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[29:28] == 2'd1) |=> ##1 !irq_pulse); // R5

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_addr |-> (rd_data[31:30] == 2'b00 && rd_data[27:24] == 4'h0)); // R2

   AST_PIN_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr) |=> (io0_is_te == $past(wr_data[29]))); // R10
endmodule

bind disp_trig_irq disp_trig_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .mode_q     (cfg_mode),
   .io0_is_te  (io0_is_te),
   .irq_pulse  (irq_pulse),
   .irq_status (irq_status)
);

// File: tb/test_disp_trig_irq.sv
module test_disp_trig_irq;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // each entry: {M[7:0], N[15:0], expected period[15:0]}
   localparam logic [39:0] VEC [NVEC] = '{
      {8'd0,   16'd0, 16'd4},
      {8'd1,   16'd0, 16'd8},
      {8'd0,   16'd1, 16'd8},
      {8'd2,   16'd3, 16'd48},
      {8'd4,   16'd1, 16'd40},
      {8'd255, 16'd0, 16'd1024}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_addr = 1'b0;
   logic [31:0] rd_data;
   logic        te_pin = 1'b0;
   logic        io0_is_te;
   logic        irq_pulse;
   logic        irq_status;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_trig_irq i_disp_trig_irq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .te_pin(te_pin), .io0_is_te(io0_is_te), .irq_pulse(irq_pulse),
      .irq_status(irq_status)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // write one word; returns at the negedge after the write edge
   task automatic wr(input logic a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [31:0] cfg(input int m, input int n, input int mode);
      return {2'b00, 2'(mode), 4'h0, 16'(n), 8'(m)};
   endfunction

   task automatic cycles_to_pulse(input int limit, output int cnt);
      cnt = 0;
      while (cnt < limit) begin
         @(negedge clk);
         cnt++;
         if (irq_pulse) break;
      end
   endtask

   task automatic count_pulses(input int ncyc, output int cnt);
      cnt = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (irq_pulse) cnt++;
      end
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd_addr = 1'b0; #1;
      check("R1 cfg", rd_data, 0);
      rd_addr = 1'b1; #1;
      check("R1 status", rd_data, 0);
      check("R1 pulse", irq_pulse, 0);
      check("R1 pin claim", io0_is_te, 0);

      // R2 layout and reserved bits
      wr(1'b0, 32'hFFFF_FFFF);
      rd_addr = 1'b0; #1;
      check("R2 all ones", rd_data, 32'h30FF_FFFF);
      check("R10 mode3 claim", io0_is_te, 1);
      wr(1'b0, cfg(8'hA5, 16'h1234, 2));
      #1;
      check("R2 fields", rd_data, 32'h2012_34A5);
      check("R10 mode2 claim", io0_is_te, 1);
      count_pulses(40, c);
      check("R11 no periodic in TE mode", c, 0);

      // R3/R4 table of periods
      for (int v = 0; v < NVEC; v++) begin
         int m, n, p;
         m = int'(VEC[v][39:32]); n = int'(VEC[v][31:16]); p = int'(VEC[v][15:0]);
         wr(1'b0, cfg(m, n, 1));
         check("R10 counter no claim", io0_is_te, 0);
         cycles_to_pulse(4000, c);
         check("R3 first period", c, p);
         cycles_to_pulse(4000, c);
         check("R3 repeat period", c, p);
         @(negedge clk);
         check("R4 single cycle", irq_pulse, 0);
      end

      // R5 restart on write
      wr(1'b0, cfg(0, 1, 1));
      repeat (5) @(negedge clk);
      wr(1'b0, cfg(0, 1, 1));
      cycles_to_pulse(100, c);
      check("R5 restart", c, 8);

      // R9 set wins over clear, then clear works
      wr(1'b1, 32'h1);
      wr(1'b0, cfg(0, 0, 1));
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_addr = 1'b1; wr_data = 32'h1;
      @(negedge clk);
      check("R9 collision pulse", irq_pulse, 1);
      check("R9 set wins", irq_status, 1);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      check("R9 cleared", irq_status, 0);
      wr(1'b0, cfg(0, 0, 0));
      rd_addr = 1'b1;
      wr(1'b1, 32'h1);
      #1;
      check("R9 status word after clear", rd_data, 0);

      // R8 disabled ignores TE
      te_pin = 1'b1;
      count_pulses(6, c);
      te_pin = 1'b0;
      c += 0;
      begin
         int c2;
         count_pulses(30, c2);
         check("R8 no pulse when off", c + c2, 0);
      end
      check("R8 status untouched", irq_status, 0);

      // R6 rising mode latency and one-per-edge
      wr(1'b0, cfg(0, 0, 2));
      te_pin = 1'b1;
      @(negedge clk); check("R6 lat e1", irq_pulse, 0);
      @(negedge clk); check("R6 lat e2", irq_pulse, 0);
      @(negedge clk); check("R6 pulse", irq_pulse, 1);
      @(negedge clk); check("R6 one pulse", irq_pulse, 0);
      te_pin = 1'b0;
      count_pulses(8, c);
      check("R6 falling ignored", c, 0);

      // R7 falling mode
      wr(1'b0, cfg(0, 0, 3));
      te_pin = 1'b1;
      count_pulses(8, c);
      check("R7 rising ignored", c, 0);
      te_pin = 1'b0;
      @(negedge clk); @(negedge clk);
      @(negedge clk); check("R7 pulse", irq_pulse, 1);
      count_pulses(8, c);
      check("R7 one pulse", c, 0);
      check("R9 set by TE pulse", irq_status, 1);

      done = 1'b1;
   end

   initial begin
      int t;
      t = 0;
      while (!done && t < 150000) begin
         @(negedge clk);
         t++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule